// File: doc/BRIEF.md
# Binary Trie Longest-Prefix Lookup Engine

This block finds the output interface for a destination address by longest-prefix match. The prefixes live as a binary trie in a small on-chip node store. The lookup starts at the root node and takes one key bit per clock cycle, beginning with the most significant bit. A zero bit follows the left child and a one bit follows the right child. On the way down, the engine keeps the port of the deepest node that marks the end of a stored prefix. When the walk ends, it returns that port, or it raises a miss flag if no prefix node was on the path.

A control agent loads the trie through a single-word write port while the engine is idle. The data path presents a key with a start strobe. The engine takes the key only when it is not busy, and it reports the outcome with a one-cycle result-valid pulse. A walk visits one node per cycle, so the latency equals the number of nodes on the path: at most one more than the key width.

Top module: `prefix_trie_lookup`

## Requirements
- R1: A node word is {prefixValid, port[PORT_W], leftIdx[IDX_W], rightIdx[IDX_W]}, with prefixValid in the most significant bit and rightIdx in the least significant bits. A write with wrEn high while the engine is idle stores wrData at node wrAddr, and that node is used from the next lookup on.
- R2: The walk starts at node 0, which is the root, and consumes key bits from the most significant bit downward. A 0 bit selects leftIdx and a 1 bit selects rightIdx. A child index of 0 means there is no child.
- R3: When several stored prefixes lie on the key's path, resPort is the port of the deepest one. This includes a root marked as a default route.
- R4: The walk stops on a null child or after all KEY_W bits are used. The node reached after the last bit is still tested for a prefix.
- R5: If no node on the path has prefixValid set, resMiss is 1 and resPort is 0. Otherwise resMiss is 0.
- R6: start is accepted only while busy is low. busy is high from the cycle after acceptance until the result cycle. A start while busy is ignored and produces no extra result.
- R7: Node writes requested while busy is high are dropped and leave the trie unchanged.
- R8: After reset, busy and resValid are 0 and every node word is cleared, so any lookup misses.
- R9: Each accepted lookup gives exactly one resValid pulse, one cycle long. busy is low in that cycle.
- R10: resValid rises N clock edges after the edge that accepted start, where N is the number of nodes the walk visited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a lookup of key |
| key | input | KEY_W | Destination address, most significant bit used first |
| busy | output | 1 | Walk in progress; start and writes are ignored |
| resValid | output | 1 | One-cycle pulse: resPort and resMiss are valid |
| resPort | output | PORT_W | Port of the longest matching prefix, 0 on a miss |
| resMiss | output | 1 | No stored prefix matched the key |
| wrEn | input | 1 | Node write strobe |
| wrAddr | input | IDX_W | Node index to write |
| wrData | input | 1+PORT_W+2*IDX_W | Node word as laid out in R1 |

## Verification
The case hardest to reach from the ports is a full-depth walk. In that case the node at the last key bit holds the answer, the walk runs for KEY_W+1 cycles, and the stop comes from running out of bits rather than from a null child. The stimulus loads a separate 33-node chain that follows one 32-bit address. It puts prefix marks at depths 16, 24 and 32, then issues the exact address and nearby addresses that leave the chain at different depths. Writes and second starts during a walk are timed to land inside the known walk latency, so that a wrongly accepted write or start would change a result the bench can observe.

// File: rtl/trie_lpm_pkg.sv
package trie_lpm_pkg;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } walk_strobe_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_state_t;

endpackage

// File: rtl/trie_node_store.sv
module trie_node_store #(
  parameter int NODE_CNT = 64,
  parameter int IDX_W    = 6,
  parameter int NODE_W   = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [NODE_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [NODE_W-1:0] rdWord
);

  localparam int FLAT_W = NODE_CNT * NODE_W;

  logic [FLAT_W-1:0] flatWords;

  for (genvar i = 0; i < NODE_CNT; i++) begin : g_word
    logic [NODE_W-1:0] wordQ;

    always_ff @(posedge clk) begin
      if (rst) begin
        wordQ <= '0;
      end else if (we && (wrAddr == IDX_W'(i))) begin
        wordQ <= wrData;
      end
    end

    assign flatWords[i*NODE_W +: NODE_W] = wordQ;
  end

  assign rdWord = flatWords[rdIdx*NODE_W +: NODE_W];

endmodule

// File: rtl/trie_walk_ctrl.sv
module trie_walk_ctrl
  import trie_lpm_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         wrEn,
  input  logic         stopNow,
  output walk_strobe_t strobe,
  output logic         busy,
  output logic         memWe
);

  walk_state_t stateQ;
  walk_state_t stateD;
  logic        isIdle;

  assign isIdle = (stateQ == ST_IDLE);

  always_comb begin
    strobe.load   = isIdle && start;
    strobe.step   = !isIdle && !stopNow;
    strobe.finish = !isIdle && stopNow;
  end

  always_comb begin
    stateD = stateQ;
    if (strobe.load) begin
      stateD = ST_WALK;
    end else if (strobe.finish) begin
      stateD = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  assign busy  = !isIdle;
  assign memWe = isIdle && wrEn;

endmodule

// File: rtl/trie_walk_dp.sv
module trie_walk_dp
  import trie_lpm_pkg::*;
#(
  parameter int KEY_W   = 32,
  parameter int PORT_W  = 4,
  parameter int IDX_W   = 6,
  parameter int DEPTH_W = 6,
  parameter int NODE_W  = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  walk_strobe_t      strobe,
  input  logic [KEY_W-1:0]  startKey,
  input  logic [NODE_W-1:0] nodeWord,
  output logic [IDX_W-1:0]  rdIdx,
  output logic              stopNow,
  output logic              resValid,
  output logic [PORT_W-1:0] resPort,
  output logic              resMiss
);

  localparam logic [DEPTH_W-1:0] LAST_DEPTH = DEPTH_W'(KEY_W);

  logic [KEY_W-1:0]   keyQ;
  logic [IDX_W-1:0]   curIdxQ;
  logic [DEPTH_W-1:0] depthQ;
  logic               foundQ;
  logic [PORT_W-1:0]  bestPortQ;

  logic               nodeValid;
  logic [PORT_W-1:0]  nodePort;
  logic [IDX_W-1:0]   nodeLeft;
  logic [IDX_W-1:0]   nodeRight;
  logic [IDX_W-1:0]   childIdx;
  logic               outOfBits;
  logic               mergedFound;
  logic [PORT_W-1:0]  mergedPort;

  assign nodeValid = nodeWord[NODE_W-1];
  assign nodePort  = nodeWord[NODE_W-2 -: PORT_W];
  assign nodeLeft  = nodeWord[2*IDX_W-1 -: IDX_W];
  assign nodeRight = nodeWord[IDX_W-1:0];

  assign childIdx    = keyQ[KEY_W-1] ? nodeRight : nodeLeft;
  assign outOfBits   = (depthQ == LAST_DEPTH);
  assign stopNow     = outOfBits || (childIdx == '0);
  assign mergedFound = foundQ || nodeValid;
  assign mergedPort  = nodeValid ? nodePort : bestPortQ;
  assign rdIdx       = curIdxQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      keyQ      <= '0;
      curIdxQ   <= '0;
      depthQ    <= '0;
      foundQ    <= 1'b0;
      bestPortQ <= '0;
    end else if (strobe.load) begin
      keyQ      <= startKey;
      curIdxQ   <= '0;
      depthQ    <= '0;
      foundQ    <= 1'b0;
      bestPortQ <= '0;
    end else if (strobe.step) begin
      keyQ      <= keyQ << 1;
      curIdxQ   <= childIdx;
      depthQ    <= depthQ + 1'b1;
      foundQ    <= mergedFound;
      bestPortQ <= mergedPort;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid <= 1'b0;
      resPort  <= '0;
      resMiss  <= 1'b0;
    end else begin
      resValid <= strobe.finish;
      if (strobe.finish) begin
        resPort <= mergedFound ? mergedPort : '0;
        resMiss <= !mergedFound;
      end
    end
  end

endmodule

// File: rtl/prefix_trie_lookup.sv
module prefix_trie_lookup
  import trie_lpm_pkg::*;
#(
  parameter int KEY_W    = 32,
  parameter int PORT_W   = 4,
  parameter int NODE_CNT = 64,
  parameter int IDX_W    = $clog2(NODE_CNT),
  parameter int NODE_W   = 1 + PORT_W + 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [KEY_W-1:0]  key,
  output logic              busy,
  output logic              resValid,
  output logic [PORT_W-1:0] resPort,
  output logic              resMiss,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [NODE_W-1:0] wrData
);

  localparam int DEPTH_W = $clog2(KEY_W + 1);

  walk_strobe_t      strobe;
  logic              stopNow;
  logic              memWe;
  logic [IDX_W-1:0]  rdIdx;
  logic [NODE_W-1:0] nodeWord;

  trie_walk_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .wrEn   (wrEn),
    .stopNow(stopNow),
    .strobe (strobe),
    .busy   (busy),
    .memWe  (memWe)
  );

  trie_node_store #(
    .NODE_CNT(NODE_CNT),
    .IDX_W   (IDX_W),
    .NODE_W  (NODE_W)
  ) store_i (
    .clk   (clk),
    .rst   (rst),
    .we    (memWe),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdIdx (rdIdx),
    .rdWord(nodeWord)
  );

  trie_walk_dp #(
    .KEY_W  (KEY_W),
    .PORT_W (PORT_W),
    .IDX_W  (IDX_W),
    .DEPTH_W(DEPTH_W),
    .NODE_W (NODE_W)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .startKey(key),
    .nodeWord(nodeWord),
    .rdIdx   (rdIdx),
    .stopNow (stopNow),
    .resValid(resValid),
    .resPort (resPort),
    .resMiss (resMiss)
  );

endmodule

// File: rtl/trie_lpm_chk.sv
module trie_lpm_chk #(
  parameter int KEY_W  = 32,
  parameter int PORT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              resValid,
  input logic              resMiss,
  input logic [PORT_W-1:0] resPort,
  input logic              memWe
);

  localparam int RUN_W = $clog2(KEY_W + 3);

  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      busyRun <= '0;
    end else if (busy) begin
      busyRun <= busyRun + 1'b1;
    end else begin
      busyRun <= '0;
    end
  end

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    resValid |=> !resValid);

  // R9
  idle_on_result_chk: assert property (@(posedge clk) disable iff (rst)
    resValid |-> !busy);

  // R5
  miss_port_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (resValid && resMiss) |-> (resPort == '0));

  // R6
  accept_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R6
  walk_ends_result_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> resValid);

  // R7
  no_write_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !memWe);

  // R8
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !resValid));

  // R4
  walk_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busyRun <= RUN_W'(KEY_W + 1));

endmodule

bind prefix_trie_lookup trie_lpm_chk #(
  .KEY_W (KEY_W),
  .PORT_W(PORT_W)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .resValid(resValid),
  .resMiss (resMiss),
  .resPort (resPort),
  .memWe   (memWe)
);

// File: tb/prefix_trie_lookup_tb_top.sv
module prefix_trie_lookup_tb_top;

  localparam int KEY_W    = 32;
  localparam int PORT_W   = 4;
  localparam int NODE_CNT = 64;
  localparam int IDX_W    = 6;
  localparam int NODE_W   = 1 + PORT_W + 2 * IDX_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [KEY_W-1:0]  key = '0;
  logic              busy;
  logic              resValid;
  logic [PORT_W-1:0] resPort;
  logic              resMiss;
  logic              wrEn = 1'b0;
  logic [IDX_W-1:0]  wrAddr = '0;
  logic [NODE_W-1:0] wrData = '0;

  int testCnt = 0;
  int failCnt = 0;
  int cycleCnt = 0;

  always #2 clk = ~clk;

  prefix_trie_lookup #(
    .KEY_W   (KEY_W),
    .PORT_W  (PORT_W),
    .NODE_CNT(NODE_CNT)
  ) dut_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .key     (key),
    .busy    (busy),
    .resValid(resValid),
    .resPort (resPort),
    .resMiss (resMiss),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData)
  );

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 100000) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycleCnt);
      finishRun();
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic writeNode(input int idx, input bit pv, input int port,
                           input int left, input int right);
    @(negedge clk);
    wrEn   = 1'b1;
    wrAddr = IDX_W'(idx);
    wrData = {pv, PORT_W'(port), IDX_W'(left), IDX_W'(right)};
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic lookup(input logic [KEY_W-1:0] k, output int port,
                        output bit miss, output int lat);
    @(negedge clk);
    start = 1'b1;
    key   = k;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!resValid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    port = int'(resPort);
    miss = resMiss;
  endtask

  function automatic logic [KEY_W-1:0] k5(input logic [4:0] b);
    return {b, 27'b0};
  endfunction

  task automatic expectHit(input logic [KEY_W-1:0] k, input int expPort,
                           input string req);
    int p; bit m; int l;
    lookup(k, p, m, l);
    check(l < 100, req, "result arrived", l, 0);
    check(!m && p == expPort, req, "port of longest match", p, expPort);
  endtask

  task automatic expectMiss(input logic [KEY_W-1:0] k, input string req);
    int p; bit m; int l;
    lookup(k, p, m, l);
    check(m == 1'b1, req, "miss flag", m, 1);
    check(p == 0, req, "port on miss", p, 0);
  endtask

  // Reset state and lookups on an empty store: R8, R5
  task automatic tReset();
    check(busy == 1'b0, "R8", "busy after reset", busy, 0);
    check(resValid == 1'b0, "R8", "resValid after reset", resValid, 0);
    expectMiss(k5(5'b01100), "R8");
  endtask

  // Table: 001xx->2, 0100x->3, 10xxx->1, 01100->5, loaded while idle (R1)
  task automatic tLoadTable();
    writeNode(0, 0, 0, 1, 2);
    writeNode(1, 0, 0, 3, 5);
    writeNode(2, 0, 0, 11, 0);
    writeNode(3, 0, 0, 0, 4);
    writeNode(4, 1, 2, 0, 0);
    writeNode(5, 0, 0, 6, 8);
    writeNode(6, 0, 0, 7, 0);
    writeNode(7, 1, 3, 0, 0);
    writeNode(8, 0, 0, 9, 0);
    writeNode(9, 0, 0, 10, 0);
    writeNode(10, 1, 5, 0, 0);
    writeNode(11, 1, 1, 0, 0);
  endtask

  // Basic walks: R1, R2, R3, R5, R10
  task automatic tBasic();
    int p; bit m; int l;
    lookup(k5(5'b01100), p, m, l);
    check(!m && p == 5, "R3", "key 01100 port", p, 5);
    check(l == 6, "R10", "latency six nodes", l, 6);
    expectHit(k5(5'b01001), 3, "R3");
    expectMiss(k5(5'b11000), "R5");
    expectHit(k5(5'b00111), 2, "R2");
    expectHit(k5(5'b10101), 1, "R2");
    expectMiss(k5(5'b01101), "R5");
    lookup(k5(5'b11000), p, m, l);
    check(l == 2, "R10", "latency two nodes on null child", l, 2);
  endtask

  // Default route at root: longer prefixes still win (R3)
  task automatic tDefault();
    writeNode(0, 1, 7, 1, 2);
    expectHit(k5(5'b11000), 7, "R3");
    expectHit(k5(5'b01100), 5, "R3");
    expectHit(k5(5'b01001), 3, "R3");
    writeNode(0, 0, 0, 1, 2);
  endtask

  // Start during a walk is ignored: R6, R9
  task automatic tBusyStart();
    int pulses = 0;
    int p;
    @(negedge clk);
    start = 1'b1;
    key   = k5(5'b01100);
    @(negedge clk);
    key = k5(5'b00111);
    check(busy == 1'b1, "R6", "busy after accept", busy, 1);
    @(negedge clk);
    start = 1'b0;
    p = -1;
    for (int i = 0; i < 15; i++) begin
      if (resValid) begin
        pulses++;
        p = int'(resPort);
      end
      @(negedge clk);
    end
    check(pulses == 1, "R9", "result pulses for one accepted start", pulses, 1);
    check(p == 5, "R6", "result belongs to first key", p, 5);
  endtask

  // Writes during a walk are dropped, idle writes land: R7, R1
  task automatic tBusyWrite();
    int p; bit m; int l;
    @(negedge clk);
    start = 1'b1;
    key   = k5(5'b01100);
    @(negedge clk);
    start  = 1'b0;
    wrEn   = 1'b1;
    wrAddr = IDX_W'(10);
    wrData = {1'b1, PORT_W'(9), IDX_W'(0), IDX_W'(0)};
    @(negedge clk);
    wrEn = 1'b0;
    while (!resValid) @(negedge clk);
    check(int'(resPort) == 5, "R7", "walk after busy write", int'(resPort), 5);
    expectHit(k5(5'b01100), 5, "R7");
    writeNode(10, 1, 9, 0, 0);
    lookup(k5(5'b01100), p, m, l);
    check(p == 9, "R1", "idle write takes effect", p, 9);
    writeNode(10, 1, 5, 0, 0);
  endtask

  // 32-level chain along 12.82.100.101 with marks at /16, /24, /32: R4, R10
  task automatic tFullDepth();
    logic [KEY_W-1:0] base;
    int p; bit m; int l;
    base = {8'd12, 8'd82, 8'd100, 8'd101};
    for (int d = 0; d <= 32; d++) begin
      bit pv;
      int port;
      int lc;
      int rc;
      pv = (d == 16) || (d == 24) || (d == 32);
      port = (d == 16) ? 3 : (d == 24) ? 2 : (d == 32) ? 9 : 0;
      lc = 0;
      rc = 0;
      if (d < 32) begin
        if (base[31-d]) rc = d + 1;
        else lc = d + 1;
      end
      writeNode(d, pv, port, lc, rc);
    end
    lookup(base, p, m, l);
    check(!m && p == 9, "R4", "exact /32 after last bit", p, 9);
    check(l == 33, "R10", "full depth latency", l, 33);
    expectHit({8'd12, 8'd82, 8'd100, 8'd7}, 2, "R3");
    expectHit({8'd12, 8'd82, 8'd7, 8'd1}, 3, "R3");
    expectMiss({8'd12, 8'd83, 8'd0, 8'd0}, "R5");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tReset();
    tLoadTable();
    tBasic();
    tDefault();
    tBusyStart();
    tBusyWrite();
    tFullDepth();
    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule